// File: doc/BRIEF.md
# Drift-Trimmed Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds for a network time clock. On every running clock cycle it advances by a fixed nominal step. A rate trim adjusts it now and then: a packed 32-bit drift word names an interval, a correction of 0 to 7 ns, and whether that correction is added or taken away. When an interval has passed, the correction is folded into that one cycle's step. Software works the block through a small register port. It can stop the count, write a new time as two 32-bit halves, and start the count again. It can also hold the trim logic in reset while it writes a new drift word.

Time is read as two 32-bit halves. Reading the low half also copies the high half into a shadow register. A following read of the high half returns that copy, so a carry out of the low half between the two reads cannot produce a torn value. Working out the drift word from a parts-per-billion request is left to software.

Top module: `tod_clock`

## Requirements
- R1: After reset the count is running, the drift-reset bit reads 0 and the drift word reads 0. Register addresses: 0 control, 1 low-half load, 2 high-half load, 3 drift reset (bit 0), 4 drift word, 5 time low half, 6 time high half (shadow). Reading the control register returns the running flag in bit 0.
- R2: Writing 2 to the control register stops the count and writing 4 starts it. Any other value written there changes nothing. While stopped, the time holds its value.
- R3: Writes to the low-half and high-half load registers replace that half of the time only while the count is stopped. While it runs they are ignored.
- R4: While running with no correction due, the time advances by the nominal step (parameter, default 8 ns) on every clock.
- R5: On a correction cycle the step becomes nominal plus the correction, or nominal minus the correction (floored at 0), so the time never decreases.
- R6: Drift word layout is: bits [27:0] period in 16 ns units, bits [30:28] correction magnitude in ns, bit 31 direction (1 adds, 0 subtracts). A correction falls each time period×16+8 ns of nominal time has gone by, and a period of 0 acts as 1.
- R7: The drift word can be written only while the drift-reset bit reads 1. A write at any other time leaves it unchanged. The drift-reset bit reads back the value last written.
- R8: Reading the low half latches the high half at the same instant, and the next high-half read returns that latched value even if a carry has occurred since.
- R9: A drift word of 0 disables correction. No correction is applied while the drift-reset bit is set. Elapsed drift time restarts from zero whenever the count is stopped or the drift reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Register read strobe (needed for the low-half latch) |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Read data, combinational from rdAddr |

## Verification
The time is always loaded to a known value while stopped and then run for a counted number of edges, so each expected value is exact. Runs with the trim disabled, with period 1 adding, with period 1 subtracting, with period 0, and with period 2 over ten edges each yield a different final time. That separates a wrong interval, a wrong sign, a missing clamp of period 0 and a trim that stays on when it should be off. A low half of 0xFFFFFFF8 read just before a carry shows whether the high-half read is taken from the shadow or from the live count.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam logic [REG_W-1:0] CMD_PAUSE  = 32'd2;
  localparam logic [REG_W-1:0] CMD_RESUME = 32'd4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOAD_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOAD_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DRIFT_RST = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DRIFT_CFG = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_TIME_LO   = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_TIME_HI   = 3'd6;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic snapLo;
  } dpStrobes_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [REG_W-1:0]    wrData,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [2*REG_W-1:0]  timeNow,
  input  logic [REG_W-1:0]    shadowHi,
  output logic [REG_W-1:0]    rdData,
  output logic                running,
  output logic                driftRst,
  output logic [REG_W-1:0]    driftCfg,
  output dpStrobes_t          strobes
);
  logic wrCtrl, wrDrst, wrCfg;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrDrst = wrEn && (wrAddr == ADDR_DRIFT_RST);
  assign wrCfg  = wrEn && (wrAddr == ADDR_DRIFT_CFG) && driftRst;

  assign strobes.loadLo = wrEn && (wrAddr == ADDR_LOAD_LO) && !running;
  assign strobes.loadHi = wrEn && (wrAddr == ADDR_LOAD_HI) && !running;
  assign strobes.snapLo = rdEn && (rdAddr == ADDR_TIME_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b1;
      driftRst <= 1'b0;
      driftCfg <= '0;
    end else begin
      if (wrCtrl && wrData == CMD_PAUSE)       running <= 1'b0;
      else if (wrCtrl && wrData == CMD_RESUME) running <= 1'b1;
      if (wrDrst) driftRst <= wrData[0];
      if (wrCfg)  driftCfg <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL:      rdData = {{(REG_W-1){1'b0}}, running};
      ADDR_DRIFT_RST: rdData = {{(REG_W-1){1'b0}}, driftRst};
      ADDR_DRIFT_CFG: rdData = driftCfg;
      ADDR_TIME_LO:   rdData = timeNow[REG_W-1:0];
      ADDR_TIME_HI:   rdData = shadowHi;
      default:        rdData = '0;
    endcase
  end

  AST_CFG_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    !driftRst |=> $stable(driftCfg)); // R7
  AST_BAD_CMD_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && wrData != CMD_PAUSE && wrData != CMD_RESUME) |=> $stable(running)); // R2
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int STEP_NS  = 8,
  parameter int PERIOD_W = 28,
  parameter int MAG_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               running,
  input  logic               driftRst,
  input  logic [REG_W-1:0]   driftCfg,
  input  logic [REG_W-1:0]   loadData,
  input  dpStrobes_t         strobes,
  output logic [2*REG_W-1:0] timeNow,
  output logic [REG_W-1:0]   shadowHi
);
  localparam int TIME_W = 2 * REG_W;
  localparam int ACC_W  = PERIOD_W + 6;
  localparam logic [ACC_W-1:0]  STEP_ACC  = ACC_W'(STEP_NS);
  localparam logic [TIME_W-1:0] STEP_TIME = TIME_W'(STEP_NS);

  logic [PERIOD_W-1:0] periodRaw, periodEff;
  logic [MAG_W-1:0]    corrMag;
  logic                corrAdd;
  logic [ACC_W-1:0]    intervalNs, acc, accSum;
  logic                driftOn, corrDue;
  logic [TIME_W-1:0]   magTime, stepNow;

  assign periodRaw  = driftCfg[PERIOD_W-1:0];
  assign corrMag    = driftCfg[REG_W-2 -: MAG_W];
  assign corrAdd    = driftCfg[REG_W-1];
  assign periodEff  = (periodRaw == '0) ? PERIOD_W'(1) : periodRaw;
  assign intervalNs = {2'b00, periodEff, 4'b0000} + ACC_W'(8);

  assign driftOn = running && !driftRst && (driftCfg != '0);
  assign accSum  = acc + STEP_ACC;
  assign corrDue = driftOn && (accSum >= intervalNs);
  assign magTime = TIME_W'(corrMag);

  always_comb begin
    stepNow = STEP_TIME;
    if (corrDue) begin
      if (corrAdd)                 stepNow = STEP_TIME + magTime;
      else if (magTime > STEP_TIME) stepNow = '0;
      else                         stepNow = STEP_TIME - magTime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (!driftOn) begin
      acc <= '0;
    end else if (corrDue) begin
      acc <= accSum - intervalNs;
    end else begin
      acc <= accSum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeNow  <= '0;
      shadowHi <= '0;
    end else begin
      if (strobes.loadLo)      timeNow[REG_W-1:0]      <= loadData;
      else if (strobes.loadHi) timeNow[TIME_W-1:REG_W] <= loadData;
      else if (running)        timeNow                 <= timeNow + stepNow;
      if (strobes.snapLo) shadowHi <= timeNow[TIME_W-1:REG_W];
    end
  end

  AST_PAUSED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobes.loadLo && !strobes.loadHi) |=> $stable(timeNow)); // R2
  AST_NO_BACKWARDS: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strobes.loadLo && !strobes.loadHi) |=> timeNow >= $past(timeNow)); // R5
  AST_NO_LOAD_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !strobes.loadLo && !strobes.loadHi); // R3
  AST_ACC_BELOW_INTERVAL: assert property (@(posedge clk) disable iff (!rstN)
    acc < intervalNs); // R6
  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (!running || driftRst) |=> acc == '0); // R9
  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.snapLo |=> $stable(shadowHi)); // R8
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int STEP_NS  = 8,
  parameter int PERIOD_W = 28,
  parameter int MAG_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData
);
  logic               running, driftRst;
  logic [REG_W-1:0]   driftCfg, shadowHi;
  logic [2*REG_W-1:0] timeNow;
  dpStrobes_t         strobes;

  tod_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .timeNow(timeNow), .shadowHi(shadowHi), .rdData(rdData),
    .running(running), .driftRst(driftRst), .driftCfg(driftCfg),
    .strobes(strobes)
  );

  tod_datapath #(.STEP_NS(STEP_NS), .PERIOD_W(PERIOD_W), .MAG_W(MAG_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .running(running), .driftRst(driftRst), .driftCfg(driftCfg),
    .loadData(wrData), .strobes(strobes),
    .timeNow(timeNow), .shadowHi(shadowHi)
  );
endmodule

// File: tb/sim_tod_clock.sv
module sim_tod_clock;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tod_clock u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    #2 d = rdData;
    @(posedge clk); #1 rdEn = 1'b0;
  endtask

  task automatic readTime(output logic [63:0] t);
    logic [31:0] lo, hi;
    rd(3'd5, lo); rd(3'd6, hi);
    t = {hi, lo};
  endtask

  task automatic loadStopped(input logic [63:0] t);
    wr(3'd0, 32'd2); wr(3'd1, t[31:0]); wr(3'd2, t[63:32]);
  endtask

  task automatic setDrift(input logic [31:0] cfg);
    wr(3'd3, 32'd1); wr(3'd4, cfg); wr(3'd3, 32'd0);
  endtask

  // resume, wait, stop: counts gap+1 running edges
  task automatic runEdges(input int gap);
    wr(3'd0, 32'd4);
    repeat (gap) @(posedge clk);
    wr(3'd0, 32'd2);
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(3'd0, d); chk("R1 running after reset", d, 1);
    rd(3'd3, d); chk("R1 drift reset clear", d, 0);
    rd(3'd4, d); chk("R1 drift word zero", d, 0);
  endtask

  task automatic testPauseLoad();
    logic [63:0] t;
    logic [31:0] d;
    loadStopped(64'h5_0000_0100);
    readTime(t); chk("R3 load while stopped", t, 64'h5_0000_0100);
    repeat (5) @(posedge clk);
    wr(3'd0, 32'd3);
    rd(3'd0, d); chk("R2 other control value ignored", d, 0);
    readTime(t); chk("R2 stopped time holds", t, 64'h5_0000_0100);
  endtask

  task automatic testRun();
    logic [63:0] t;
    setDrift(32'h0);
    loadStopped(64'h1000);
    runEdges(9);
    readTime(t); chk("R4 nominal step 10 edges", t, 64'h1000 + 80);
    loadStopped(64'h2000);
    wr(3'd0, 32'd4); wr(3'd1, 32'h0); wr(3'd0, 32'd2);
    readTime(t); chk("R3 load ignored while running", t, 64'h2000 + 16);
  endtask

  task automatic testDrift();
    logic [63:0] t;
    logic [31:0] d;
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, d); chk("R7 drift word write blocked", d, 0);
    wr(3'd3, 32'd1);
    rd(3'd3, d); chk("R7 drift reset reads back", d, 1);
    wr(3'd4, 32'hD000_0001);
    rd(3'd4, d); chk("R7 drift word accepted", d, 32'hD000_0001);
    loadStopped(64'h0);
    runEdges(5);
    readTime(t); chk("R9 no trim while drift reset held", t, 48);
    wr(3'd3, 32'd0);
    loadStopped(64'h0);
    runEdges(5);
    readTime(t); chk("R6 period1 add 5", t, 58);
    setDrift(32'h7000_0001);
    loadStopped(64'h0);
    runEdges(5);
    readTime(t); chk("R5 period1 subtract 7", t, 34);
    setDrift(32'hB000_0000);
    loadStopped(64'h0);
    runEdges(5);
    readTime(t); chk("R6 period0 acts as 1", t, 54);
    setDrift(32'h9000_0002);
    loadStopped(64'h0);
    runEdges(9);
    readTime(t); chk("R6 period2 add 1", t, 82);
    setDrift(32'h0);
    loadStopped(64'h0);
    runEdges(5);
    readTime(t); chk("R9 zero word disables", t, 48);
  endtask

  task automatic testShadow();
    logic [31:0] lo, hi;
    loadStopped(64'h1_FFFF_FFF8);
    wr(3'd0, 32'd4);
    rd(3'd5, lo); rd(3'd6, hi);
    chk("R8 low half before carry", lo, 32'hFFFF_FFF8);
    chk("R8 high half from shadow", hi, 1);
    wr(3'd0, 32'd2);
    rd(3'd5, lo); rd(3'd6, hi);
    chk("R8 after carry", {hi, lo}, 64'h2_0000_0010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testPauseLoad();
    testRun();
    testDrift();
    testShadow();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule